// File: doc/BRIEF.md
# Carrier Bus Slave Front-End

This block is the slave side of a 16-bit carrier bus on a plug-in module whose data lines pass through external level-shifting buffers. It watches four active-low select lines (identification, I/O, interrupt and memory space), adds one fixed wait state to every cycle so the buffers have time to settle, and returns a single-cycle active-low acknowledge. It decodes reads from each space into a registered 16-bit read word.

The external buffers need a direction control for each byte lane. The block points both lanes inbound (carrier to module) by default and turns them outbound only while a read cycle is in progress. A small control word at I/O word 0 holds a strobe-line direction bit and a sticky request to hand the module back to configuration mode. The hand-off output is held back until the acknowledge of the requesting write has been released, so the bus master never sees a write that was not acknowledged.

Top module: `ipb_slave_front`

## Requirements
- R1: After reset, ack_n is 1, both lane_out_en bits are 0 (inbound), cfg_en is 0 (user mode) and strobe_dir is 0 (strobe line is an input).
- R2: When a select is first sampled low on clock edge k, ack_n stays 1 after edge k (the wait state), is 0 after edge k+1 for exactly one cycle, and no further acknowledge is given until every select has been sampled high.
- R3: Both lane_out_en bits are 1 (module drives the bus) after edges k and k+1 of a read cycle in any of the four spaces, and 0 during write cycles and when idle; the two bits are always equal.
- R4: An identification read of word address 5 (byte offset 0x0A) returns 0x0049, word address 6 returns 0x0021, and any other word returns 0x0000.
- R5: I/O word 0 reads back {14'b0, strobe_dir, config request}; I/O word 1 is a 16-bit read/write scratch word reset to 0; other I/O words read 0x0000.
- R6: An interrupt-space read returns the vector 0x00A5 and is acknowledged like any other cycle.
- R7: A memory-space read returns the 6-bit word address zero-extended to 16 bits; memory-space writes change no register.
- R8: An I/O write to word 0 with data bit 0 set raises the config request; cfg_en then rises on the first edge after the acknowledge has returned high, i.e. after edge k+3 of that write.
- R9: Once set, the config request and cfg_en stay 1 until reset; writing 0 to word 0 does not clear them.
- R10: Data bit 1 of an I/O write to word 0 sets strobe_dir (1 = strobe line is an output) or clears it (0 = input).
- R11: Writes to identification or interrupt space change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all outputs change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_sel_n | input | 1 | Identification-space select, active low |
| io_sel_n | input | 1 | I/O-space select, active low |
| int_sel_n | input | 1 | Interrupt-space select, active low |
| mem_sel_n | input | 1 | Memory-space select, active low |
| rw_n | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Word address |
| wdata | input | 16 | Write data from the carrier |
| rdata | output | 16 | Registered read data, valid while ack_n is 0 on a read |
| ack_n | output | 1 | Cycle acknowledge, active low |
| lane_out_en | output | 2 | Buffer direction per byte lane, bit 0 for data 7:0, bit 1 for data 15:8; 1 = outbound |
| strobe_dir | output | 1 | Strobe-line direction, 1 = output |
| cfg_en | output | 1 | 1 = return to configuration mode, 0 = user mode |

## Verification
Reads are issued in all four spaces with differing addresses, so a wrong space decode or a swapped lookup shows up as a wrong word rather than a plausible one, and the lane directions are compared between reads and writes to tell read steering from mere select activity. Writes are aimed at the control word, the scratch word and the spaces that must ignore them, then read back, which separates a correct write decode from one that leaks across spaces. The control-word write is followed edge by edge to tell a hand-off released after the acknowledge from one released with it, and a master that holds its select past the acknowledge checks that no second acknowledge is produced.

// File: rtl/ipb_pkg.sv
package ipb_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_HOLD} ipb_state_e;
  typedef enum logic [1:0] {SP_ID, SP_IO, SP_INT, SP_MEM} ipb_space_e;
endpackage

// File: rtl/ipb_cycle_fsm.sv
module ipb_cycle_fsm
  import ipb_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        sel_n_i,
  input  logic              rw_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ack_n_o,
  output logic              xfer_o,
  output logic              drv_next_o,
  output ipb_space_e        space_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o
);
  ipb_state_e        state_q, state_d;
  ipb_space_e        space_q, space_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              ack_q, ack_d;
  logic              any_sel;

  assign any_sel = ~&sel_n_i;

  always_comb begin
    state_d = state_q;
    space_d = space_q;
    rd_d    = rd_q;
    addr_d  = addr_q;
    unique case (state_q)
      ST_IDLE: begin
        if (any_sel) begin
          state_d = ST_WAIT;
          rd_d    = rw_n_i;
          addr_d  = addr_i;
          if (!sel_n_i[0])      space_d = SP_ID;
          else if (!sel_n_i[1]) space_d = SP_IO;
          else if (!sel_n_i[2]) space_d = SP_INT;
          else                  space_d = SP_MEM;
        end
      end
      ST_WAIT: state_d = ST_ACK;
      ST_ACK:  state_d = any_sel ? ST_HOLD : ST_IDLE;
      ST_HOLD: state_d = any_sel ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
    ack_d = (state_q != ST_WAIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      space_q <= SP_ID;
      rd_q    <= 1'b0;
      addr_q  <= '0;
      ack_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      space_q <= space_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      ack_q   <= ack_d;
    end
  end

  assign xfer_o     = (state_q == ST_WAIT);
  assign drv_next_o = rd_d && ((state_d == ST_WAIT) || (state_d == ST_ACK));
  assign ack_n_o    = ack_q;
  assign space_o    = space_q;
  assign rd_o       = rd_q;
  assign addr_o     = addr_q;

  // R2: acknowledge lasts a single cycle
  assert_ack_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_q |=> ack_q);
  // R2: acknowledge only after a select held through the wait state
  assert_wait_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_q) |-> ($past(any_sel) && $past(any_sel, 2)));
endmodule

// File: rtl/ipb_lane_dir.sv
module ipb_lane_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic drv_next_i,
  output logic out_en_o
);
  logic en_q, en_d;

  always_comb en_d = drv_next_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign out_en_o = en_q;
endmodule

// File: rtl/ipb_regs.sv
module ipb_regs
  import ipb_pkg::*;
#(
  parameter int          ADDR_W     = 6,
  parameter int          DATA_W     = 16,
  parameter int          ID_BYTE_OFS = 10,
  parameter logic [7:0]  USER_ID    = 8'h49,
  parameter logic [7:0]  MODEL_CODE = 8'h21,
  parameter logic [DATA_W-1:0] VECTOR = 16'h00A5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_i,
  input  ipb_space_e        space_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              ack_n_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              strobe_dir_o,
  output logic              cfg_en_o
);
  localparam int ID_WORD    = ID_BYTE_OFS / 2;
  localparam int MODEL_WORD = ID_WORD + 1;
  localparam logic [ADDR_W-1:0] CTRL_WORD    = '0;
  localparam logic [ADDR_W-1:0] SCRATCH_WORD = ADDR_W'(1);

  logic              req_q, req_d;
  logic              strb_q, strb_d;
  logic [DATA_W-1:0] scr_q, scr_d;
  logic [DATA_W-1:0] rdat_q, rdat_d;
  logic              cfg_q, cfg_d;
  logic              io_wr;

  function automatic logic [7:0] id_byte(input logic [ADDR_W-1:0] w);
    if (w == ADDR_W'(ID_WORD))         return USER_ID;
    else if (w == ADDR_W'(MODEL_WORD)) return MODEL_CODE;
    else                               return 8'h00;
  endfunction

  assign io_wr = xfer_i && !rd_i && (space_i == SP_IO);

  always_comb begin
    req_d  = req_q;
    strb_d = strb_q;
    scr_d  = scr_q;
    rdat_d = rdat_q;
    if (io_wr && addr_i == CTRL_WORD) begin
      req_d  = req_q | wdata_i[0];
      strb_d = wdata_i[1];
    end
    if (io_wr && addr_i == SCRATCH_WORD) scr_d = wdata_i;
    if (xfer_i && rd_i) begin
      unique case (space_i)
        SP_ID:  rdat_d = {{(DATA_W-8){1'b0}}, id_byte(addr_i)};
        SP_IO: begin
          if (addr_i == CTRL_WORD)         rdat_d = {{(DATA_W-2){1'b0}}, strb_q, req_q};
          else if (addr_i == SCRATCH_WORD) rdat_d = scr_q;
          else                             rdat_d = '0;
        end
        SP_INT: rdat_d = VECTOR;
        SP_MEM: rdat_d = {{(DATA_W-ADDR_W){1'b0}}, addr_i};
        default: rdat_d = '0;
      endcase
    end
    // hand-off waits until the acknowledge has been released
    cfg_d = cfg_q | (req_q & ack_n_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      strb_q <= 1'b0;
      scr_q  <= '0;
      rdat_q <= '0;
      cfg_q  <= 1'b0;
    end else begin
      req_q  <= req_d;
      strb_q <= strb_d;
      scr_q  <= scr_d;
      rdat_q <= rdat_d;
      cfg_q  <= cfg_d;
    end
  end

  assign rdata_o      = rdat_q;
  assign strobe_dir_o = strb_q;
  assign cfg_en_o     = cfg_q;

  // R9: hand-off output never falls once raised
  assert_cfg_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q |=> cfg_q);
  // R8: hand-off rises only with the acknowledge already released
  assert_cfg_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_q) |-> ($past(ack_n_i) && ack_n_i));
  // R9: request bit is sticky
  assert_req_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> req_q);
endmodule

// File: rtl/ipb_slave_front.sv
module ipb_slave_front
  import ipb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_sel_n,
  input  logic              io_sel_n,
  input  logic              int_sel_n,
  input  logic              mem_sel_n,
  input  logic              rw_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ack_n,
  output logic [DATA_W/8-1:0] lane_out_en,
  output logic              strobe_dir,
  output logic              cfg_en
);
  localparam int LANES = DATA_W / 8;

  ipb_space_e        space;
  logic              rd, xfer, drv_next;
  logic [ADDR_W-1:0] addr_q;

  ipb_cycle_fsm #(.ADDR_W(ADDR_W)) i_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_n_i   ({mem_sel_n, int_sel_n, io_sel_n, id_sel_n}),
    .rw_n_i    (rw_n),
    .addr_i    (addr),
    .ack_n_o   (ack_n),
    .xfer_o    (xfer),
    .drv_next_o(drv_next),
    .space_o   (space),
    .rd_o      (rd),
    .addr_o    (addr_q)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      ipb_lane_dir i_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .drv_next_i(drv_next),
        .out_en_o  (lane_out_en[g])
      );
      // R3: every lane agrees with lane 0
      assert_lanes_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lane_out_en[g] == lane_out_en[0]);
    end
  endgenerate

  ipb_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_i      (xfer),
    .space_i     (space),
    .rd_i        (rd),
    .addr_i      (addr_q),
    .wdata_i     (wdata),
    .ack_n_i     (ack_n),
    .rdata_o     (rdata),
    .strobe_dir_o(strobe_dir),
    .cfg_en_o    (cfg_en)
  );

  // R3: buffers point outbound only for a read request
  assert_dir_read_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lane_out_en[0] |-> $past(rw_n));
endmodule

// File: tb/test_ipb_slave_front.sv
module test_ipb_slave_front;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        id_sel_n = 1'b1, io_sel_n = 1'b1, int_sel_n = 1'b1, mem_sel_n = 1'b1;
  logic        rw_n = 1'b1;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ack_n;
  logic [1:0]  lane_out_en;
  logic        strobe_dir, cfg_en;

  int n_chk = 0, n_bad = 0;
  bit mon_rd = 1'b0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ipb_slave_front i_ipb_slave_front (
    .clk(clk), .rst_n(rst_n), .id_sel_n(id_sel_n), .io_sel_n(io_sel_n),
    .int_sel_n(int_sel_n), .mem_sel_n(mem_sel_n), .rw_n(rw_n), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .lane_out_en(lane_out_en),
    .strobe_dir(strobe_dir), .cfg_en(cfg_en)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // monitor: compares read data against the scoreboard while acknowledged
  always @(negedge clk) begin
    if (!ack_n && mon_rd) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R4-7 read: actual %h expected none", rdata);
      end else begin
        check("R4/R5/R6/R7 read data", rdata, exp_q.pop_front());
        check("R3 drive during ack", {14'b0, lane_out_en}, 16'h0003);
      end
    end
  end

  // sp: 0 id, 1 io, 2 int, 3 mem
  task automatic bus_cycle(input int sp, input bit rd, input logic [5:0] a,
                           input logic [15:0] wd, input logic [15:0] exp, input int hold);
    @(negedge clk);
    if (rd) exp_q.push_back(exp);
    mon_rd = rd;
    rw_n = rd; addr = a; wdata = wd;
    id_sel_n = (sp != 0); io_sel_n = (sp != 1); int_sel_n = (sp != 2); mem_sel_n = (sp != 3);
    @(negedge clk);
    check("R2 wait state", {15'b0, ack_n}, 16'h0001);
    check("R3 direction", {14'b0, lane_out_en}, rd ? 16'h0003 : 16'h0000);
    @(negedge clk);
    check("R2 ack asserted", {15'b0, ack_n}, 16'h0000);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R2 no repeat ack", {15'b0, ack_n}, 16'h0001);
    end
    id_sel_n = 1'b1; io_sel_n = 1'b1; int_sel_n = 1'b1; mem_sel_n = 1'b1;
    @(negedge clk);
    mon_rd = 1'b0;
    check("R2 ack released", {15'b0, ack_n}, 16'h0001);
    check("R3 inbound idle", {14'b0, lane_out_en}, 16'h0000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      check("scoreboard drained", 16'(exp_q.size()), 16'h0000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ack_n", {15'b0, ack_n}, 16'h0001);
    check("R1 lanes", {14'b0, lane_out_en}, 16'h0000);
    check("R1 cfg_en", {15'b0, cfg_en}, 16'h0000);
    check("R1 strobe_dir", {15'b0, strobe_dir}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 identification reads
    bus_cycle(0, 1, 6'd5, 16'h0, 16'h0049, 0);
    bus_cycle(0, 1, 6'd6, 16'h0, 16'h0021, 0);
    bus_cycle(0, 1, 6'd0, 16'h0, 16'h0000, 0);
    // R6 interrupt vector
    bus_cycle(2, 1, 6'd0, 16'h0, 16'h00A5, 0);
    // R7 memory echo, R2 held select
    bus_cycle(3, 1, 6'h2A, 16'h0, 16'h002A, 2);
    // R5 scratch
    bus_cycle(1, 0, 6'd1, 16'hBEEF, 16'h0, 0);
    bus_cycle(1, 1, 6'd1, 16'h0, 16'hBEEF, 0);
    // R7 memory write has no effect
    bus_cycle(3, 0, 6'd1, 16'h1234, 16'h0, 0);
    bus_cycle(1, 1, 6'd1, 16'h0, 16'hBEEF, 0);
    bus_cycle(1, 1, 6'd0, 16'h0, 16'h0000, 0);
    bus_cycle(1, 1, 6'd3, 16'h0, 16'h0000, 0);
    // R11 writes to id and interrupt space ignored
    bus_cycle(0, 0, 6'd0, 16'h0003, 16'h0, 0);
    bus_cycle(2, 0, 6'd0, 16'h0003, 16'h0, 0);
    check("R11 cfg_en", {15'b0, cfg_en}, 16'h0000);
    check("R11 strobe_dir", {15'b0, strobe_dir}, 16'h0000);
    bus_cycle(1, 1, 6'd0, 16'h0, 16'h0000, 0);
    // R10 strobe direction
    bus_cycle(1, 0, 6'd0, 16'h0002, 16'h0, 0);
    check("R10 strobe set", {15'b0, strobe_dir}, 16'h0001);
    check("R10 no cfg", {15'b0, cfg_en}, 16'h0000);
    bus_cycle(1, 1, 6'd0, 16'h0, 16'h0002, 0);
    bus_cycle(1, 0, 6'd0, 16'h0000, 16'h0, 0);
    check("R10 strobe clear", {15'b0, strobe_dir}, 16'h0000);
    // R8 hand-off timing
    bus_cycle(1, 0, 6'd0, 16'h0001, 16'h0, 0);
    check("R8 cfg held during release", {15'b0, cfg_en}, 16'h0000);
    @(negedge clk);
    check("R8 cfg raised", {15'b0, cfg_en}, 16'h0001);
    bus_cycle(1, 1, 6'd0, 16'h0, 16'h0001, 0);
    // R9 sticky
    bus_cycle(1, 0, 6'd0, 16'h0000, 16'h0, 0);
    check("R9 cfg sticky", {15'b0, cfg_en}, 16'h0001);
    bus_cycle(1, 1, 6'd0, 16'h0, 16'h0001, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule